// File: doc/BRIEF.md
# Clock Source Mode Transition Controller

This block holds the control state that picks a small microcontroller's system clock: the main oscillator, a PLL, a low-frequency sub clock or an on-chip ring oscillator, together with the CPU clock divider and the wait and stop power states. Software changes the state through a narrow register write port. The controller works out which operating mode the write would produce and checks the move against a set of legal transitions. A refused write changes nothing and raises an error pulse.

Some control bits are forced by hardware. Stopping the main oscillator and leaving stop mode both turn on the fixed divide-by-8 setting. A wait request parks the CPU clock, and an interrupt brings it back. The outputs give the selected source, the effective divide ratio, the power state and the oscillator enables.

Operating modes are derived from the control bits:
- sub selected gives sub mode;
- otherwise ring selected gives ring mode;
- otherwise PLL selected gives PLL mode;
- otherwise main gives high-speed mode when the effective ratio is 1, and middle-speed mode when it is not.

Top module: `clkmode_ctrl`

## Requirements
- R1: After reset `src_sel`=0, `div_ratio`=8, `pwr_state`=0, `main_osc_en`=1, `sub_osc_en`=0, `pll_en`=0 and `wr_err`=0.
- R2: The register map is as follows. Address 0 holds {sub_sel, fix8, main_off, sub_en} in bits 3..0. Address 1 holds {div_sel[1:0], pll_sel, stop_cmd} in bits 3..0. Address 2 bit1 is ring_sel and bit0 is mon_en. Address 3 bit0 is pll_on. With fix8=0, `div_ratio` follows div_sel: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 16. With fix8=1 the ratio is 8 whatever div_sel holds.
- R3: `src_sel` encodes the source as 0 for main, 1 for PLL, 2 for sub and 3 for ring. sub_sel has priority over ring_sel, and ring_sel has priority over pll_sel.
- R4: An accepted address-0 write with main_off=1 also sets fix8, whatever bit2 of the write carries.
- R5: PLL mode is entered only from high-speed mode and left only to high-speed mode. Any other entry into or exit from PLL mode is refused.
- R6: A move from ring mode to high- or middle-speed mode is refused unless fix8 is already 1.
- R7: A move into sub mode is refused while `sub_osc_ok` is 0.
- R8: While mon_en is 1, any write that changes the mode is refused, and so is a stop command. Writes that keep the mode are accepted.
- R9: A write that would leave main_off=1 with main or PLL as the source is refused.
- R10: A refused write leaves all state unchanged. `wr_err` is 1 for exactly the cycle after the write edge. Accepted writes take effect at that same edge.
- R11: In run state, an accepted address-1 write with bit0=1 enters stop (`pwr_state`=2), and the other bits of that write are ignored. An `irq` returns the block to run and sets fix8.
- R12: `wait_req` in run state enters wait (`pwr_state`=1), and `irq` returns to run without touching the divider. Writes in wait or stop are ignored without error. `irq` in run state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Register address |
| wr_data | input | 4 | Register write data |
| wait_req | input | 1 | Request to enter wait state |
| irq | input | 1 | Interrupt; wakes from wait or stop |
| sub_osc_ok | input | 1 | Sub clock is oscillating |
| src_sel | output | 2 | Selected clock source |
| div_ratio | output | 5 | Effective CPU clock divide ratio |
| pwr_state | output | 2 | 0 run, 1 wait, 2 stop |
| main_osc_en | output | 1 | Main oscillator enabled |
| sub_osc_en | output | 1 | Sub oscillator enabled |
| pll_en | output | 1 | PLL enabled |
| wr_err | output | 1 | Refused write indication |

## Verification
Every result is due one edge after its stimulus. This covers the new source, the ratio, the power state and the error flag, since all of them come from state registered at the write, request or interrupt edge. The bench drives a stimulus for a single cycle from the falling edge, lets one rising edge pass and samples at the following falling edge. Refused writes are checked twice: once for the error pulse in that sampling cycle, and once for the unchanged outputs. The divider is swept over every field and fix combination, and each refusal rule is probed with a write that differs from an accepted one in a single condition.

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [3:0] wr_data,
  input  logic       wait_req,
  input  logic       irq,
  input  logic       sub_osc_ok,
  output logic [1:0] src_sel,
  output logic [4:0] div_ratio,
  output logic [1:0] pwr_state,
  output logic       main_osc_en,
  output logic       sub_osc_en,
  output logic       pll_en,
  output logic       wr_err
);
  localparam logic [2:0] MD_HI = 3'd0, MD_MID = 3'd1, MD_PLL = 3'd2, MD_SUB = 3'd3, MD_RING = 3'd4;
  localparam logic [1:0] SRC_MAIN = 2'd0, SRC_PLL = 2'd1, SRC_SUB = 2'd2, SRC_RING = 2'd3;
  localparam logic [1:0] PW_RUN = 2'd0, PW_WAIT = 2'd1, PW_STOP = 2'd2;

  logic       sub_en, main_off, fix8, sub_sel, pll_sel, mon_en, ring_sel, pll_on, err_q;
  logic [1:0] div_sel, pwr;

  logic       n_sub_en, n_main_off, n_fix8, n_sub_sel, n_pll_sel, n_mon_en, n_ring_sel, n_pll_on;
  logic [1:0] n_div_sel;
  logic       stop_try;

  function automatic logic [2:0] mode_of(input logic s, input logic r, input logic p,
                                         input logic f8, input logic [1:0] ds);
    if (s)                    return MD_SUB;
    else if (r)               return MD_RING;
    else if (p)               return MD_PLL;
    else if (!f8 && ds == 2'd0) return MD_HI;
    else                      return MD_MID;
  endfunction

  function automatic logic [1:0] src_of(input logic s, input logic r, input logic p);
    if (s)      return SRC_SUB;
    else if (r) return SRC_RING;
    else if (p) return SRC_PLL;
    else        return SRC_MAIN;
  endfunction

  always_comb begin
    n_sub_en   = sub_en;
    n_main_off = main_off;
    n_fix8     = fix8;
    n_sub_sel  = sub_sel;
    n_pll_sel  = pll_sel;
    n_div_sel  = div_sel;
    n_mon_en   = mon_en;
    n_ring_sel = ring_sel;
    n_pll_on   = pll_on;
    stop_try   = 1'b0;
    case (wr_addr)
      2'd0: begin
        n_sub_en   = wr_data[0];
        n_main_off = wr_data[1];
        n_fix8     = wr_data[2] | wr_data[1];
        n_sub_sel  = wr_data[3];
      end
      2'd1: begin
        if (wr_data[0]) stop_try = 1'b1;
        else begin
          n_pll_sel = wr_data[1];
          n_div_sel = wr_data[3:2];
        end
      end
      2'd2: begin
        n_mon_en   = wr_data[0];
        n_ring_sel = wr_data[1];
      end
      default: n_pll_on = wr_data[0];
    endcase
  end

  logic [2:0] cur_md, nxt_md;
  logic [1:0] nxt_src;
  logic       chg, rej_mon, rej_pll, rej_ring, rej_sub, rej_off, reject, wr_go;

  assign cur_md  = mode_of(sub_sel, ring_sel, pll_sel, fix8, div_sel);
  assign nxt_md  = mode_of(n_sub_sel, n_ring_sel, n_pll_sel, n_fix8, n_div_sel);
  assign nxt_src = src_of(n_sub_sel, n_ring_sel, n_pll_sel);
  assign chg     = nxt_md != cur_md;

  assign rej_mon  = mon_en && (chg || stop_try);
  assign rej_pll  = chg && ((nxt_md == MD_PLL && cur_md != MD_HI) ||
                            (cur_md == MD_PLL && nxt_md != MD_HI));
  assign rej_ring = chg && cur_md == MD_RING && (nxt_md == MD_HI || nxt_md == MD_MID) && !fix8;
  assign rej_sub  = chg && nxt_md == MD_SUB && !sub_osc_ok;
  assign rej_off  = n_main_off && (nxt_src == SRC_MAIN || nxt_src == SRC_PLL);
  assign reject   = rej_mon | rej_pll | rej_ring | rej_sub | rej_off;
  assign wr_go    = wr_en && pwr == PW_RUN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_en   <= 1'b0;
      main_off <= 1'b0;
      fix8     <= 1'b1;
      sub_sel  <= 1'b0;
      pll_sel  <= 1'b0;
      div_sel  <= 2'd0;
      mon_en   <= 1'b0;
      ring_sel <= 1'b0;
      pll_on   <= 1'b0;
      pwr      <= PW_RUN;
      err_q    <= 1'b0;
    end else begin
      err_q <= wr_go && reject;
      case (pwr)
        PW_RUN:  if (wait_req) pwr <= PW_WAIT;
        PW_WAIT: if (irq) pwr <= PW_RUN;
        default: if (irq) begin
          pwr  <= PW_RUN;
          fix8 <= 1'b1;
        end
      endcase
      if (wr_go && !reject) begin
        sub_en   <= n_sub_en;
        main_off <= n_main_off;
        fix8     <= n_fix8;
        sub_sel  <= n_sub_sel;
        pll_sel  <= n_pll_sel;
        div_sel  <= n_div_sel;
        mon_en   <= n_mon_en;
        ring_sel <= n_ring_sel;
        pll_on   <= n_pll_on;
        if (stop_try) pwr <= PW_STOP;
      end
    end
  end

  always_comb begin
    if (fix8) div_ratio = 5'd8;
    else begin
      case (div_sel)
        2'd0:    div_ratio = 5'd1;
        2'd1:    div_ratio = 5'd2;
        2'd2:    div_ratio = 5'd4;
        default: div_ratio = 5'd16;
      endcase
    end
  end

  assign src_sel     = src_of(sub_sel, ring_sel, pll_sel);
  assign pwr_state   = pwr;
  assign main_osc_en = !main_off;
  assign sub_osc_en  = sub_en;
  assign pll_en      = pll_on;
  assign wr_err      = err_q;
endmodule

module clkmode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       sub_osc_ok,
  input logic [1:0] src_sel,
  input logic [4:0] div_ratio,
  input logic [1:0] pwr_state,
  input logic       main_osc_en,
  input logic       wr_err
);
  assert_err_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> ($past(wr_en) && $past(pwr_state) == 2'd0));
  assert_reject_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> ($stable(src_sel) && $stable(div_ratio) && $stable(main_osc_en)));
  assert_stop_exit_fix8_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd0 && $past(pwr_state) == 2'd2) |-> div_ratio == 5'd8);
  assert_main_off_fix8_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !main_osc_en |-> div_ratio == 5'd8);
  assert_pll_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'd1 && $past(src_sel) != 2'd1) |-> ($past(src_sel) == 2'd0 && $past(div_ratio) == 5'd1));
  assert_pll_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel != 2'd1 && $past(src_sel) == 2'd1) |-> (src_sel == 2'd0 && div_ratio == 5'd1));
  assert_ring_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_sel) == 2'd3 && src_sel == 2'd0) |-> div_ratio == 5'd8);
  assert_sub_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'd2 && $past(src_sel) != 2'd2) |-> $past(sub_osc_ok));
  assert_main_off_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !main_osc_en |-> src_sel[1]);
endmodule

bind clkmode_ctrl clkmode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sub_osc_ok(sub_osc_ok),
  .src_sel(src_sel), .div_ratio(div_ratio), .pwr_state(pwr_state),
  .main_osc_en(main_osc_en), .wr_err(wr_err)
);

// File: tb/test_clkmode_ctrl.sv
module test_clkmode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [3:0] wr_data = 4'd0;
  logic       wait_req = 1'b0;
  logic       irq = 1'b0;
  logic       sub_osc_ok = 1'b0;
  logic [1:0] src_sel, pwr_state;
  logic [4:0] div_ratio;
  logic       main_osc_en, sub_osc_en, pll_en, wr_err;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  clkmode_ctrl i_clkmode_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wait_req(wait_req), .irq(irq), .sub_osc_ok(sub_osc_ok),
    .src_sel(src_sel), .div_ratio(div_ratio), .pwr_state(pwr_state),
    .main_osc_en(main_osc_en), .sub_osc_en(sub_osc_en), .pll_en(pll_en), .wr_err(wr_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d, input logic exp_err, input string req);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    check(req, {31'd0, wr_err}, {31'd0, exp_err});
  endtask

  task automatic pulse_irq();
    @(negedge clk); irq = 1'b1;
    @(posedge clk);
    @(negedge clk); irq = 1'b0;
  endtask

  task automatic pulse_wait();
    @(negedge clk); wait_req = 1'b1;
    @(posedge clk);
    @(negedge clk); wait_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", {src_sel, div_ratio, pwr_state, main_osc_en, sub_osc_en, pll_en, wr_err},
          {2'd0, 5'd8, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0});

    for (int dv = 0; dv < 4; dv++) begin
      for (int f8 = 0; f8 < 2; f8++) begin
        wr(2'd1, 4'(dv << 2), 1'b0, "R2 div field write");
        wr(2'd0, 4'(f8 << 2), 1'b0, "R2 fix8 write");
        check("R2 ratio", {27'd0, div_ratio},
              (f8 == 1) ? 32'd8 : (dv == 3) ? 32'd16 : (32'd1 << dv));
      end
    end

    wr(2'd1, 4'd0, 1'b0, "R2 clear field");
    wr(2'd0, 4'd0, 1'b0, "R2 high speed");
    check("R3 main source", {src_sel, div_ratio}, {2'd0, 5'd1});
    wr(2'd3, 4'd1, 1'b0, "R2 pll_on");
    check("R2 pll enable", {31'd0, pll_en}, 32'd1);
    wr(2'd1, 4'b0010, 1'b0, "R5 pll entry from high speed");
    check("R5 pll selected", {src_sel, div_ratio}, {2'd1, 5'd1});

    sub_osc_ok = 1'b1;
    wr(2'd0, 4'b1001, 1'b1, "R5 pll to sub refused");
    check("R5 still pll", {30'd0, src_sel}, 32'd1);
    wr(2'd1, 4'b0100, 1'b1, "R5 pll to middle refused");
    check("R10 unchanged after refusal", {src_sel, div_ratio}, {2'd1, 5'd1});
    @(negedge clk);
    check("R10 error lasts one cycle", {31'd0, wr_err}, 32'd0);
    wr(2'd1, 4'b0000, 1'b0, "R5 pll exit to high speed");
    check("R5 back on main", {src_sel, div_ratio}, {2'd0, 5'd1});

    wr(2'd0, 4'b0100, 1'b0, "R2 middle speed");
    wr(2'd1, 4'b0010, 1'b1, "R5 pll from middle refused");
    check("R5 main kept", {30'd0, src_sel}, 32'd0);

    sub_osc_ok = 1'b0;
    wr(2'd0, 4'b1101, 1'b1, "R7 sub without oscillation refused");
    check("R7 unchanged", {src_sel, sub_osc_en}, {2'd0, 1'b0});
    sub_osc_ok = 1'b1;
    wr(2'd0, 4'b1101, 1'b0, "R7 sub with oscillation");
    check("R7 sub selected", {src_sel, sub_osc_en}, {2'd2, 1'b1});

    wr(2'd0, 4'b1011, 1'b0, "R4 main stop write");
    check("R4 forced fix8", {main_osc_en, div_ratio}, {1'b0, 5'd8});
    wr(2'd0, 4'b1101, 1'b0, "R4 main restart");
    check("R4 main on", {src_sel, main_osc_en}, {2'd2, 1'b1});
    wr(2'd0, 4'b0010, 1'b1, "R9 main stop with main source refused");
    check("R9 unchanged", {src_sel, main_osc_en}, {2'd2, 1'b1});

    wr(2'd2, 4'b0010, 1'b0, "R3 ring select under sub");
    check("R3 sub over ring", {30'd0, src_sel}, 32'd2);
    wr(2'd0, 4'b0101, 1'b0, "R3 sub off");
    check("R3 ring source", {src_sel, div_ratio}, {2'd3, 5'd8});
    wr(2'd0, 4'b0001, 1'b0, "R2 ring ratio change");
    check("R2 ring ratio", {src_sel, div_ratio}, {2'd3, 5'd1});
    wr(2'd2, 4'b0000, 1'b1, "R6 ring exit without fix8 refused");
    check("R6 still ring", {30'd0, src_sel}, 32'd3);
    wr(2'd0, 4'b0101, 1'b0, "R6 set fix8");
    wr(2'd2, 4'b0000, 1'b0, "R6 ring exit with fix8");
    check("R6 main source", {src_sel, div_ratio}, {2'd0, 5'd8});

    wr(2'd2, 4'b0001, 1'b0, "R8 monitor on");
    wr(2'd0, 4'b0001, 1'b1, "R8 mode change refused");
    check("R8 ratio unchanged", {27'd0, div_ratio}, 32'd8);
    wr(2'd1, 4'b0001, 1'b1, "R8 stop refused");
    check("R8 stays run", {30'd0, pwr_state}, 32'd0);
    wr(2'd1, 4'b0100, 1'b0, "R8 same mode accepted");
    wr(2'd2, 4'b0000, 1'b0, "R8 monitor off");

    wr(2'd1, 4'b0000, 1'b0, "R2 field clear");
    wr(2'd0, 4'b0001, 1'b0, "R2 high speed again");
    check("R2 ratio one", {27'd0, div_ratio}, 32'd1);
    wr(2'd1, 4'b1001, 1'b0, "R11 stop command");
    check("R11 stop entered, field ignored", {pwr_state, div_ratio}, {2'd2, 5'd1});
    wr(2'd0, 4'b0101, 1'b0, "R12 write in stop no error");
    check("R12 write in stop ignored", {27'd0, div_ratio}, 32'd1);
    pulse_irq();
    check("R11 stop exit sets fix8", {pwr_state, div_ratio}, {2'd0, 5'd8});

    wr(2'd0, 4'b0001, 1'b0, "R12 prepare ratio");
    pulse_wait();
    check("R12 wait entered", {30'd0, pwr_state}, 32'd1);
    wr(2'd0, 4'b0101, 1'b0, "R12 write in wait no error");
    check("R12 write in wait ignored", {27'd0, div_ratio}, 32'd1);
    pulse_irq();
    check("R12 wait exit keeps ratio", {pwr_state, div_ratio}, {2'd0, 5'd1});
    pulse_irq();
    check("R12 irq in run no effect", {pwr_state, src_sel, div_ratio}, {2'd0, 2'd0, 5'd1});

    finish_run();
  end
endmodule